// File: doc/BRIEF.md
# Target in-band event request controller

This block sits on the target side of a two-wire controller/target bus. It lets the target ask for attention in one of three ways: an in-band interrupt, a request to take over the controller role, or a hot-join. Software posts a request by writing a two-bit event code, with an optional data byte for the interrupt kind. The block then waits for a suitable bus condition, asks an abstract bus engine to drive the request, and tracks the answer. A refused request goes back to waiting and is tried again automatically. The block ends with a one-cycle completion pulse once the request is acknowledged and any interrupt data byte has been sent.

The bus engine does the signalling and bit-level arbitration. A free-running idle-time counter outside the block supplies two level inputs: `bus_avail`, the shorter wait, and `bus_idle`, the longer one. Interrupts and role requests start on `bus_avail`. A hot-join starts only on `bus_idle`.

The control is one state machine with five states:

- `S_IDLE`: nothing in flight.
- `S_WAIT`: waiting for the bus condition.
- `S_REQ`: the request is being driven.
- `S_DATA`: acknowledged, and the interrupt byte is going out.
- `S_DONE`: the one-cycle completion state.

Its transitions are:

- `S_IDLE`→`S_WAIT` on a write of a non-zero code.
- `S_WAIT`→`S_IDLE` on a cancel, which is a write of zero before the first request.
- `S_WAIT`→`S_REQ` when the condition for the code holds.
- `S_REQ`→`S_WAIT` on a refusal.
- `S_REQ`→`S_DATA` on an acknowledge with a byte pending.
- `S_REQ`→`S_DONE` on an acknowledge with no byte.
- `S_DATA`→`S_DONE` when the engine reports the byte sent.
- `S_DONE`→`S_IDLE` unconditionally.

Top module: `tgt_evreq`

## Requirements
- R1: After reset, `ev_status` is 0, `ev_code` is 0, and `eng_req` and `ev_done` are low.
- R2: In `S_IDLE`, a write (`sw_wr`) of a non-zero `sw_code` is accepted. From the next cycle, `ev_code` shows that code and `ev_status` is 1 (pending, not yet sent). Codes are: 1 interrupt, 2 role request, 3 hot-join.
- R3: While waiting, codes 1 and 2 start a request on `bus_avail`, and code 3 starts only on `bus_idle` (`bus_avail` alone is ignored). `eng_req` rises in the cycle after the condition is sampled, and `eng_kind` equals the code.
- R4: A write of code 0 while waiting and before any request was driven cancels the event: from the next cycle `ev_code` is 0, `ev_status` is 0 and no request is made. Cancel takes priority over a bus condition in the same cycle.
- R5: Once a request has been driven, a write of code 0 is ignored and the event runs to completion.
- R6: On `eng_nack` while requesting (with no `eng_ack`), `eng_req` drops in the next cycle and `ev_status` becomes 2 (refused, will retry). The request is driven again on the next qualifying bus condition.
- R7: When the event completes, `ev_done` is high for exactly one cycle. In that cycle `ev_code` is 0 and `ev_status` is 3 (acknowledged).
- R8: For an interrupt posted with `sw_has_byte` set, completion waits after the acknowledge until `eng_byte_done`. In between, `eng_has_byte` is 1, `ev_status` is 3 and `eng_req` is low.
- R9: The byte on `eng_byte` is the written byte, except that bit 7 is forced to 1 when `time_ctrl_en` was high at the write and the code is 1. `eng_has_byte` is 0 for codes 2 and 3.
- R10: A write of a non-zero code while an event is in flight is ignored; `ev_code` keeps the earlier code.
- R11: After completion, `ev_status` stays 3 in `S_IDLE` until the next accepted write.
- R12: `eng_ack` and `eng_nack` have no effect unless a request is being driven. `eng_ack` wins over `eng_nack` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software write strobe for the event code |
| sw_code | input | 2 | Event code written by software |
| sw_byte | input | DATA_W | Interrupt data byte |
| sw_has_byte | input | 1 | Interrupt carries a data byte |
| time_ctrl_en | input | 1 | Time control enabled (forces the byte's top bit) |
| bus_avail | input | 1 | Bus-available condition from the idle counter |
| bus_idle | input | 1 | Bus-idle condition from the idle counter |
| eng_ack | input | 1 | Engine: request acknowledged |
| eng_nack | input | 1 | Engine: request refused |
| eng_byte_done | input | 1 | Engine: interrupt data byte sent |
| eng_req | output | 1 | Ask the engine to drive the request |
| eng_kind | output | 2 | Kind of request being driven |
| eng_byte | output | DATA_W | Data byte for the engine |
| eng_has_byte | output | 1 | A data byte follows the acknowledge |
| ev_code | output | 2 | Current event code (0 when none) |
| ev_status | output | 2 | Progress: 0 none, 1 pending, 2 refused/retry, 3 acknowledged |
| ev_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a cancel or a stray code write that arrives after a request was already driven and refused. At that point the block is back in the waiting state but must no longer honour a cancel. The bench gets there by holding `bus_avail` or `bus_idle` for a single cycle to drive one request, refusing it, and only then writing code 0. It then checks that the code survives and the retry still completes. Random events with random refusal counts, time-control settings and bytes cover the same return path many times.

// File: rtl/evq_pkg.sv
package evq_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_IBI  = 2'd1,
        EV_CTRL = 2'd2,
        EV_HJ   = 2'd3
    } ev_code_e;

    typedef enum logic [1:0] {
        PS_NONE    = 2'd0,
        PS_WAITING = 2'd1,
        PS_REFUSED = 2'd2,
        PS_ACKED   = 2'd3
    } ev_prog_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WAIT = 3'd1,
        S_REQ  = 3'd2,
        S_DATA = 3'd3,
        S_DONE = 3'd4
    } ev_state_e;

endpackage

// File: rtl/evq_cond_sel.sv
module evq_cond_sel
    import evq_pkg::*;
(
    input  ev_code_e kind,
    input  logic     bus_avail,
    input  logic     bus_idle,
    output logic     cond_ok
);

    // Hot-join needs the longer idle window; the others need bus-available.
    always_comb begin
        unique case (kind)
            EV_HJ:           cond_ok = bus_idle;
            EV_IBI, EV_CTRL: cond_ok = bus_avail;
            default:         cond_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/evq_byte_form.sv
module evq_byte_form
    import evq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  ev_code_e            kind,
    input  logic                time_ctrl_en,
    input  logic                has_byte_in,
    input  logic [DATA_W-1:0]   raw_byte,
    output logic [DATA_W-1:0]   formed_byte,
    output logic                has_byte_out
);

    localparam int MARK = DATA_W - 1;

    logic is_irq;
    assign is_irq = (kind == EV_IBI);

    // The top bit is forced to 1 only for an interrupt with time control on.
    always_comb begin
        formed_byte = raw_byte;
        if (is_irq && time_ctrl_en) begin
            formed_byte[MARK] = 1'b1;
        end
        has_byte_out = is_irq && has_byte_in;
    end

endmodule

// File: rtl/evq_fsm.sv
module evq_fsm
    import evq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  ev_code_e          sw_code,
    input  logic [DATA_W-1:0] new_byte,
    input  logic              new_has_byte,
    input  logic              cond_ok,
    input  logic              eng_ack,
    input  logic              eng_nack,
    input  logic              eng_byte_done,
    output ev_code_e          code_q,
    output logic [DATA_W-1:0] byte_q,
    output logic              has_q,
    output ev_prog_e          status,
    output logic              req,
    output logic              done
);

    ev_state_e state, nxt;
    logic      refused_q;
    logic      started_q;
    logic      last_ok_q;
    logic      wr_new;
    logic      wr_cancel;

    assign wr_new    = sw_wr && (sw_code != EV_NONE);
    assign wr_cancel = sw_wr && (sw_code == EV_NONE) && !started_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (wr_new) nxt = S_WAIT;
            S_WAIT: begin
                if (wr_cancel)    nxt = S_IDLE;
                else if (cond_ok) nxt = S_REQ;
            end
            S_REQ: begin
                if (eng_ack)       nxt = has_q ? S_DATA : S_DONE;
                else if (eng_nack) nxt = S_WAIT;
            end
            S_DATA: if (eng_byte_done) nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Event context held alongside the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q    <= EV_NONE;
            byte_q    <= '0;
            has_q     <= 1'b0;
            refused_q <= 1'b0;
            started_q <= 1'b0;
            last_ok_q <= 1'b0;
        end else begin
            if (state == S_IDLE && wr_new) begin
                code_q    <= sw_code;
                byte_q    <= new_byte;
                has_q     <= new_has_byte;
                refused_q <= 1'b0;
                started_q <= 1'b0;
                last_ok_q <= 1'b0;
            end
            if (state == S_WAIT && wr_cancel) begin
                code_q <= EV_NONE;
            end
            if (state == S_WAIT && nxt == S_REQ) begin
                started_q <= 1'b1;
            end
            if (state == S_REQ && nxt == S_WAIT) begin
                refused_q <= 1'b1;
            end
            if (nxt == S_DONE && state != S_DONE) begin
                code_q    <= EV_NONE;
                last_ok_q <= 1'b1;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        req    = 1'b0;
        done   = 1'b0;
        status = PS_NONE;
        unique case (state)
            S_IDLE: status = last_ok_q ? PS_ACKED : PS_NONE;
            S_WAIT: status = refused_q ? PS_REFUSED : PS_WAITING;
            S_REQ: begin
                req    = 1'b1;
                status = refused_q ? PS_REFUSED : PS_WAITING;
            end
            S_DATA: status = PS_ACKED;
            S_DONE: begin
                done   = 1'b1;
                status = PS_ACKED;
            end
            default: status = PS_NONE;
        endcase
    end

endmodule

// File: rtl/tgt_evreq.sv
module tgt_evreq
    import evq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [1:0]        sw_code,
    input  logic [DATA_W-1:0] sw_byte,
    input  logic              sw_has_byte,
    input  logic              time_ctrl_en,
    input  logic              bus_avail,
    input  logic              bus_idle,
    input  logic              eng_ack,
    input  logic              eng_nack,
    input  logic              eng_byte_done,
    output logic              eng_req,
    output logic [1:0]        eng_kind,
    output logic [DATA_W-1:0] eng_byte,
    output logic              eng_has_byte,
    output logic [1:0]        ev_code,
    output logic [1:0]        ev_status,
    output logic              ev_done
);

    ev_code_e          wr_code;
    ev_code_e          cur_code;
    ev_prog_e          prog;
    logic [DATA_W-1:0] formed_byte;
    logic              formed_has;
    logic              cond_ok;

    assign wr_code = ev_code_e'(sw_code);

    evq_byte_form #(.DATA_W(DATA_W)) u_form (
        .kind         (wr_code),
        .time_ctrl_en (time_ctrl_en),
        .has_byte_in  (sw_has_byte),
        .raw_byte     (sw_byte),
        .formed_byte  (formed_byte),
        .has_byte_out (formed_has)
    );

    evq_cond_sel u_cond (
        .kind      (cur_code),
        .bus_avail (bus_avail),
        .bus_idle  (bus_idle),
        .cond_ok   (cond_ok)
    );

    evq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_wr         (sw_wr),
        .sw_code       (wr_code),
        .new_byte      (formed_byte),
        .new_has_byte  (formed_has),
        .cond_ok       (cond_ok),
        .eng_ack       (eng_ack),
        .eng_nack      (eng_nack),
        .eng_byte_done (eng_byte_done),
        .code_q        (cur_code),
        .byte_q        (eng_byte),
        .has_q         (eng_has_byte),
        .status        (prog),
        .req           (eng_req),
        .done          (ev_done)
    );

    assign eng_kind  = cur_code;
    assign ev_code   = cur_code;
    assign ev_status = prog;

endmodule

// File: rtl/evq_chk.sv
module evq_chk #(
    parameter int DATA_W = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_wr,
    input logic [1:0] sw_code,
    input logic       bus_avail,
    input logic       bus_idle,
    input logic       eng_ack,
    input logic       eng_nack,
    input logic       eng_req,
    input logic [1:0] eng_kind,
    input logic [1:0] ev_code,
    input logic [1:0] ev_status,
    input logic       ev_done
);

    assert_start_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) |-> ((eng_kind == 2'd3) ? $past(bus_idle) : $past(bus_avail)));

    assert_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_code == 2'd0 && ev_status == 2'd1 && !eng_req)
        |=> (ev_status == 2'd0 && ev_code == 2'd0));

    assert_no_late_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && sw_wr && sw_code == 2'd0 && !eng_ack) |=> (ev_code != 2'd0));

    assert_refuse_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_nack && !eng_ack) |=> (!eng_req && ev_status == 2'd2));

    assert_done_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> (ev_code == 2'd0 && ev_status == 2'd3));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> !ev_done);

    assert_req_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (ev_status == 2'd1 || ev_status == 2'd2));

endmodule

bind tgt_evreq evq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr     (sw_wr),
    .sw_code   (sw_code),
    .bus_avail (bus_avail),
    .bus_idle  (bus_idle),
    .eng_ack   (eng_ack),
    .eng_nack  (eng_nack),
    .eng_req   (eng_req),
    .eng_kind  (eng_kind),
    .ev_code   (ev_code),
    .ev_status (ev_status),
    .ev_done   (ev_done)
);

// File: tb/tb_tgt_evreq.sv
module tb_tgt_evreq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_wr = 1'b0;
    logic [1:0] sw_code = 2'd0;
    logic [7:0] sw_byte = 8'd0;
    logic       sw_has_byte = 1'b0;
    logic       time_ctrl_en = 1'b0;
    logic       bus_avail = 1'b0;
    logic       bus_idle = 1'b0;
    logic       eng_ack = 1'b0;
    logic       eng_nack = 1'b0;
    logic       eng_byte_done = 1'b0;
    logic       eng_req;
    logic [1:0] eng_kind;
    logic [7:0] eng_byte;
    logic       eng_has_byte;
    logic [1:0] ev_code;
    logic [1:0] ev_status;
    logic       ev_done;

    int n_tests = 0;
    int n_fail  = 0;
    int seed_v;

    always #5 clk = ~clk;

    tgt_evreq #(.DATA_W(8)) dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] b, input logic tc, input logic [1:0] c);
        return (tc && c == 2'd1) ? (b | 8'h80) : b;
    endfunction

    task automatic set_cond(input logic [1:0] c, input logic v);
        if (c == 2'd3) bus_idle = v;
        else           bus_avail = v;
    endtask

    task automatic post(input logic [1:0] c, input logic [7:0] b, input logic h, input logic tc);
        sw_wr = 1'b1; sw_code = c; sw_byte = b; sw_has_byte = h; time_ctrl_en = tc;
        step();
        sw_wr = 1'b0;
    endtask

    // Full event: post, refuse `nacks` times, then acknowledge and finish.
    task automatic run_event(input logic [1:0] c, input logic [7:0] b, input logic h,
                             input logic tc, input int nacks);
        logic hb;
        hb = h && (c == 2'd1);
        post(c, b, h, tc);
        check("R2 code latched", ev_code, c);
        check("R2 status pending", ev_status, 2'd1);
        for (int n = 0; n <= nacks; n++) begin
            set_cond(c, 1'b1);
            step();
            set_cond(c, 1'b0);
            check("R3 request driven", eng_req, 1'b1);
            check("R3 kind", eng_kind, c);
            if (n < nacks) begin
                eng_nack = 1'b1;
                step();
                eng_nack = 1'b0;
                check("R6 request dropped", eng_req, 1'b0);
                check("R6 status refused", ev_status, 2'd2);
            end
        end
        eng_ack = 1'b1;
        step();
        eng_ack = 1'b0;
        check("R9 has byte", eng_has_byte, hb);
        if (hb) begin
            check("R8 status acked", ev_status, 2'd3);
            check("R8 no done yet", ev_done, 1'b0);
            check("R8 req low", eng_req, 1'b0);
            check("R9 byte", eng_byte, exp_byte(b, tc, c));
            eng_byte_done = 1'b1;
            step();
            eng_byte_done = 1'b0;
        end
        check("R7 done pulse", ev_done, 1'b1);
        check("R7 code zero", ev_code, 2'd0);
        check("R7 status acked", ev_status, 2'd3);
        step();
        check("R7 done single", ev_done, 1'b0);
        check("R11 status held", ev_status, 2'd3);
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        seed_v = $urandom(32'd20240611);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 status", ev_status, 2'd0);
        check("R1 code", ev_code, 2'd0);
        check("R1 req", eng_req, 1'b0);
        check("R1 done", ev_done, 1'b0);

        // Interrupt with one refusal, no byte
        run_event(2'd1, 8'h12, 1'b0, 1'b0, 1);

        // Hot-join ignores bus-available
        post(2'd3, 8'h00, 1'b0, 1'b0);
        bus_avail = 1'b1;
        step(); step();
        bus_avail = 1'b0;
        check("R3 hot-join ignores bus_avail", eng_req, 1'b0);
        // Stray acknowledge while waiting is ignored
        eng_ack = 1'b1; eng_nack = 1'b1;
        step();
        eng_ack = 1'b0; eng_nack = 1'b0;
        check("R12 ack ignored status", ev_status, 2'd1);
        check("R12 ack ignored done", ev_done, 1'b0);
        // Busy write of another code is ignored
        post(2'd2, 8'h00, 1'b0, 1'b0);
        check("R10 code kept", ev_code, 2'd3);
        // Cancel takes priority over a simultaneous condition
        bus_idle = 1'b1;
        post(2'd0, 8'h00, 1'b0, 1'b0);
        bus_idle = 1'b0;
        check("R4 cancel code", ev_code, 2'd0);
        check("R4 cancel status", ev_status, 2'd0);
        check("R4 no request", eng_req, 1'b0);
        step();
        check("R4 still idle", eng_req, 1'b0);

        // Late cancel after a refused request is ignored
        post(2'd2, 8'h00, 1'b0, 1'b0);
        bus_avail = 1'b1;
        step();
        bus_avail = 1'b0;
        sw_wr = 1'b1; sw_code = 2'd0; eng_nack = 1'b1;
        step();
        sw_wr = 1'b0; eng_nack = 1'b0;
        check("R5 code survives", ev_code, 2'd2);
        post(2'd0, 8'h00, 1'b0, 1'b0);
        check("R5 cancel ignored after start", ev_code, 2'd2);
        check("R5 status refused", ev_status, 2'd2);
        bus_avail = 1'b1;
        step();
        bus_avail = 1'b0;
        check("R6 retried", eng_req, 1'b1);
        eng_ack = 1'b1; eng_nack = 1'b1;
        step();
        eng_ack = 1'b0; eng_nack = 1'b0;
        check("R12 ack wins", ev_done, 1'b1);
        step();

        // Interrupt with byte, time control on and off
        run_event(2'd1, 8'h35, 1'b1, 1'b1, 0);
        run_event(2'd1, 8'h35, 1'b1, 1'b0, 2);
        // Role request with byte flag and time control: no byte
        run_event(2'd2, 8'h35, 1'b1, 1'b1, 0);

        // Random events
        for (int i = 0; i < 60; i++) begin
            logic [1:0] c;
            c = 2'($urandom_range(1, 3));
            run_event(c, 8'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 3)));
            repeat ($urandom_range(0, 3)) step();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule